// File: doc/BRIEF.md
# Data Processing Execute Unit with Condition Flags

This block is the execute stage for the data processing instructions of a 32-bit load/store processor. Each cycle it may accept one decoded operation: a 4-bit opcode, the first-operand register value (or the fact that the first operand names the program counter, together with the address of the instruction), a second operand that a shifter has already formed, and that shifter's carry-out. It returns the operation's result, a write-enable for the destination register and the next values of the four condition flags.

The unit folds the program-counter read-ahead into the first operand. It picks the carry flag from either the adder or the shifter, depending on the opcode class. It covers the reverse-subtract forms and the inverted-borrow carry-in convention of the subtract-with-carry forms. When the destination is the program counter and flag setting is requested, it takes the saved status flags instead of computing new ones. The outputs are registered, so each result appears one clock after it is accepted.

Top module: `dp_alu_unit`

## Requirements
- R1: Logical opcodes give these results: 0x0 = a AND b, 0x1 = a XOR b, 0xC = a OR b, 0xD = b, 0xE = a AND NOT b, 0xF = NOT b. Here a is the first operand and b is the second operand.
- R2: The compare opcodes 0x8 (test bits, AND), 0x9 (test equal, XOR), 0xA (compare, a-b) and 0xB (compare negative, a+b) never assert `rd_we`. Every other opcode asserts `rd_we` for an accepted operation.
- R3: Arithmetic opcodes give these results modulo 2^32, where c is the incoming C flag: 0x2 = a-b, 0x3 = b-a, 0x4 = a+b, 0x5 = a+b+c, 0x6 = a-b-(1-c), 0x7 = b-a-(1-c).
- R4: With flag setting on, an arithmetic or arithmetic-compare opcode sets C to the unsigned carry-out of the addition. For subtraction, C=1 means no borrow. V is set on two's-complement signed overflow of the operation.
- R5: With flag setting on, a logical or logical-compare opcode sets C to `shifter_carry` and leaves V at its incoming value.
- R6: When `rn_is_pc` is high, the first operand is `instr_addr`+8, or `instr_addr`+12 when `shift_by_reg` is high, and `rn_value` has no effect.
- R7: With flag setting on, N equals bit 31 and Z is set exactly when all bits are zero, both taken from the internal result. That result is also driven on `result` for compare opcodes.
- R8: With `set_flags` low, `flags_out` equals `flags_in` for every opcode.
- R9: With `set_flags` and `rd_is_pc` both high on a non-compare opcode, `flags_out` takes `saved_flags` and `status_restore` pulses; the result is still written.
- R10: An operation accepted with `in_valid` high appears on the outputs, with `out_valid` high, after the next rising edge. A cycle with `in_valid` low gives `out_valid`, `rd_we` and `status_restore` low.
- R11: Synchronous active-low reset clears `out_valid`, `result`, `rd_we`, `flags_out` and `status_restore`.
- R12: The flag vectors are ordered N (bit 3), Z (bit 2), C (bit 1), V (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Data processing opcode |
| rn_is_pc | input | 1 | First operand register is the program counter |
| instr_addr | input | 32 | Address of the executing instruction |
| rn_value | input | 32 | First operand register value |
| shift_by_reg | input | 1 | Second operand shifted by a register amount |
| op2_value | input | 32 | Second operand from the shifter |
| shifter_carry | input | 1 | Shifter carry-out |
| flags_in | input | 4 | Current N,Z,C,V |
| set_flags | input | 1 | Instruction requests flag update |
| rd_is_pc | input | 1 | Destination register is the program counter |
| saved_flags | input | 4 | N,Z,C,V of the saved status register |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Operation result (internal result for compares) |
| rd_we | output | 1 | Write result to destination register |
| flags_out | output | 4 | Next N,Z,C,V |
| status_restore | output | 1 | Saved status copied into current status |

## Verification
The assertions assume that every input is at a known level whenever `in_valid` is high. They also assume that `saved_flags` is only meaningful when the restore case applies. The bench drives all inputs from a task on the falling clock edge and holds them through the next rising edge, so each operation is sampled exactly once. Operands are drawn from a pool that mixes 0x80000000, 0xFFFFFFFF, 0x7FFFFFFF, 0 and 1 with free random words. The flag inputs, the shifter carry and the control bits are randomised on every operation, so every opcode is exercised with both carry-in values and with flag setting on and off.

// File: rtl/dpalu_pkg.sv
// Package: opcode encoding and opcode-class helpers shared by the execute unit.
// Assumes the conventional 4-bit data processing opcode layout decoded upstream.
package dpalu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0,
        OP_EOR = 4'h1,
        OP_SUB = 4'h2,
        OP_RSB = 4'h3,
        OP_ADD = 4'h4,
        OP_ADC = 4'h5,
        OP_SBC = 4'h6,
        OP_RSC = 4'h7,
        OP_TST = 4'h8,
        OP_TEQ = 4'h9,
        OP_CMP = 4'hA,
        OP_CMN = 4'hB,
        OP_ORR = 4'hC,
        OP_MOV = 4'hD,
        OP_BIC = 4'hE,
        OP_MVN = 4'hF
    } dp_op_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    // Compare opcodes only touch flags.
    function automatic logic op_is_compare(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

    // Opcodes whose carry and overflow come from the adder.
    function automatic logic op_is_arith(input logic [3:0] op);
        return (op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB});
    endfunction

endpackage

// File: rtl/dpalu_operand_sel.sv
// Module: first-operand selection. Replaces a program-counter read with the
// pipeline read-ahead value. Assumes instr_addr is the executing instruction's
// address and that a register-specified shift costs one extra fetch step.
module dpalu_operand_sel #(
    parameter int DW        = 32,
    parameter int PC_AHEAD  = 8,
    parameter int PC_EXTRA  = 4
) (
    input  logic          rn_is_pc,
    input  logic          shift_by_reg,
    input  logic [DW-1:0] instr_addr,
    input  logic [DW-1:0] rn_value,
    output logic [DW-1:0] op1
);
    localparam logic [DW-1:0] AHEAD_V = DW'(PC_AHEAD);
    localparam logic [DW-1:0] EXTRA_V = DW'(PC_EXTRA);

    // Pick the register value or the read-ahead program counter.
    always_comb begin
        if (rn_is_pc) begin
            op1 = instr_addr + AHEAD_V + (shift_by_reg ? EXTRA_V : '0);
        end else begin
            op1 = rn_value;
        end
    end

    // R6: a program-counter read never passes the register value through unless it matches
    always_comb begin
        if (rn_is_pc && !shift_by_reg) begin
            AST_PC_READ_AHEAD: assert (op1 - instr_addr == AHEAD_V); // R6
        end
    end
endmodule

// File: rtl/dpalu_core.sv
// Module: combinational datapath. One shared adder serves every arithmetic
// opcode by conditionally swapping and inverting operands. A bitwise unit
// covers the logical opcodes. Assumes carry_in is the current C flag.
module dpalu_core #(
    parameter int DW = 32
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          carry_in,
    output logic [DW-1:0] res,
    output logic          add_carry,
    output logic          add_ovf
);
    import dpalu_pkg::*;

    localparam int MSB = DW - 1;

    logic [DW-1:0] x_in;
    logic [DW-1:0] y_in;
    logic          c_in;
    logic [DW:0]   sum;
    logic [DW-1:0] logic_res;

    // Steer operands and carry into the shared adder.
    always_comb begin
        unique case (op)
            OP_SUB, OP_CMP: begin x_in = a;  y_in = ~b; c_in = 1'b1;     end
            OP_RSB:         begin x_in = b;  y_in = ~a; c_in = 1'b1;     end
            OP_ADD, OP_CMN: begin x_in = a;  y_in = b;  c_in = 1'b0;     end
            OP_ADC:         begin x_in = a;  y_in = b;  c_in = carry_in; end
            OP_SBC:         begin x_in = a;  y_in = ~b; c_in = carry_in; end
            OP_RSC:         begin x_in = b;  y_in = ~a; c_in = carry_in; end
            default:        begin x_in = a;  y_in = b;  c_in = 1'b0;     end
        endcase
    end

    // Single DW+1 bit addition, carry-out in the top bit.
    always_comb begin
        sum = {1'b0, x_in} + {1'b0, y_in} + {{DW{1'b0}}, c_in};
    end

    // Signed overflow: same-sign inputs produce a sum of the other sign.
    always_comb begin
        add_carry = sum[DW];
        add_ovf   = (x_in[MSB] == y_in[MSB]) && (sum[MSB] != x_in[MSB]);
    end

    // Bitwise opcodes.
    always_comb begin
        unique case (op)
            OP_AND, OP_TST: logic_res = a & b;
            OP_EOR, OP_TEQ: logic_res = a ^ b;
            OP_ORR:         logic_res = a | b;
            OP_MOV:         logic_res = b;
            OP_BIC:         logic_res = a & ~b;
            OP_MVN:         logic_res = ~b;
            default:        logic_res = '0;
        endcase
    end

    // Final result mux between adder and bitwise unit.
    always_comb begin
        res = op_is_arith(op) ? sum[MSB:0] : logic_res;
    end

    // R3: plain add must agree with operand sum
    always_comb begin
        if (op == OP_ADD) begin
            AST_ADD_SUM: assert (res == a + b); // R3
        end
    end
endmodule

// File: rtl/dpalu_flag_ctl.sv
// Module: write-enable and next-flag selection. Chooses between holding the
// flags, restoring saved flags, and computing N/Z/C/V from the datapath.
// Assumes flags use the order N,Z,C,V from bit 3 down to bit 0.
module dpalu_flag_ctl #(
    parameter int DW = 32
) (
    input  logic [3:0]    op,
    input  logic          set_flags,
    input  logic          rd_is_pc,
    input  logic [DW-1:0] res,
    input  logic          add_carry,
    input  logic          add_ovf,
    input  logic          shifter_carry,
    input  logic [3:0]    flags_in,
    input  logic [3:0]    saved_flags,
    output logic [3:0]    flags_nx,
    output logic          we_nx,
    output logic          restore_nx
);
    import dpalu_pkg::*;

    localparam int MSB = DW - 1;

    logic cmp_op;
    logic arith_op;

    // Classify the opcode once.
    always_comb begin
        cmp_op   = op_is_compare(op);
        arith_op = op_is_arith(op);
    end

    // Destination write and status-restore decisions.
    always_comb begin
        we_nx      = !cmp_op;
        restore_nx = set_flags && rd_is_pc && !cmp_op;
    end

    // Next flag value.
    always_comb begin
        if (!set_flags) begin
            flags_nx = flags_in;
        end else if (restore_nx) begin
            flags_nx = saved_flags;
        end else begin
            flags_nx[FLAG_N] = res[MSB];
            flags_nx[FLAG_Z] = (res == '0);
            flags_nx[FLAG_C] = arith_op ? add_carry : shifter_carry;
            flags_nx[FLAG_V] = arith_op ? add_ovf   : flags_in[FLAG_V];
        end
    end
endmodule

// File: rtl/dp_alu_unit.sv
// Module: top of the data processing execute unit. Joins operand selection,
// datapath and flag control, and registers every output one cycle later.
// Assumes the inputs are stable around the rising edge when in_valid is high.
module dp_alu_unit #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op_code,
    input  logic          rn_is_pc,
    input  logic [DW-1:0] instr_addr,
    input  logic [DW-1:0] rn_value,
    input  logic          shift_by_reg,
    input  logic [DW-1:0] op2_value,
    input  logic          shifter_carry,
    input  logic [3:0]    flags_in,
    input  logic          set_flags,
    input  logic          rd_is_pc,
    input  logic [3:0]    saved_flags,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          rd_we,
    output logic [3:0]    flags_out,
    output logic          status_restore
);
    import dpalu_pkg::*;

    localparam int MSB = DW - 1;

    logic [DW-1:0] op1;
    logic [DW-1:0] res_c;
    logic          carry_c;
    logic          ovf_c;
    logic [3:0]    flags_c;
    logic          we_c;
    logic          restore_c;

    dpalu_operand_sel #(.DW(DW), .PC_AHEAD(8), .PC_EXTRA(4)) u_opsel (
        .rn_is_pc     (rn_is_pc),
        .shift_by_reg (shift_by_reg),
        .instr_addr   (instr_addr),
        .rn_value     (rn_value),
        .op1          (op1)
    );

    dpalu_core #(.DW(DW)) u_core (
        .op        (op_code),
        .a         (op1),
        .b         (op2_value),
        .carry_in  (flags_in[FLAG_C]),
        .res       (res_c),
        .add_carry (carry_c),
        .add_ovf   (ovf_c)
    );

    dpalu_flag_ctl #(.DW(DW)) u_flags (
        .op            (op_code),
        .set_flags     (set_flags),
        .rd_is_pc      (rd_is_pc),
        .res           (res_c),
        .add_carry     (carry_c),
        .add_ovf       (ovf_c),
        .shifter_carry (shifter_carry),
        .flags_in      (flags_in),
        .saved_flags   (saved_flags),
        .flags_nx      (flags_c),
        .we_nx         (we_c),
        .restore_nx    (restore_c)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            result         <= '0;
            rd_we          <= 1'b0;
            flags_out      <= '0;
            status_restore <= 1'b0;
        end else begin
            out_valid      <= in_valid;
            rd_we          <= in_valid && we_c;
            status_restore <= in_valid && restore_c;
            if (in_valid) begin
                result    <= res_c;
                flags_out <= flags_c;
            end
        end
    end

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_compare(op_code)) |=> !rd_we); // R2

    AST_LOGIC_KEEP_V: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags && !op_is_arith(op_code) && !(rd_is_pc && !op_is_compare(op_code)))
        |=> (flags_out[FLAG_V] == $past(flags_in[FLAG_V])
             && flags_out[FLAG_C] == $past(shifter_carry))); // R5

    AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags && !(rd_is_pc && !op_is_compare(op_code)))
        |=> (flags_out[FLAG_Z] == (result == '0) && flags_out[FLAG_N] == result[MSB])); // R7

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !set_flags) |=> (flags_out == $past(flags_in))); // R8

    AST_RESTORE_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags && rd_is_pc && !op_is_compare(op_code))
        |=> (status_restore && rd_we && flags_out == $past(saved_flags))); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !rd_we && !status_restore)); // R10

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
endmodule

// File: tb/dp_alu_unit_tb.sv
// Bench: directed corners plus seeded random operations, checked against a
// reference model written from the requirements.
module dp_alu_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        rn_is_pc = 1'b0;
    logic [31:0] instr_addr = '0;
    logic [31:0] rn_value = '0;
    logic        shift_by_reg = 1'b0;
    logic [31:0] op2_value = '0;
    logic        shifter_carry = 1'b0;
    logic [3:0]  flags_in = '0;
    logic        set_flags = 1'b0;
    logic        rd_is_pc = 1'b0;
    logic [3:0]  saved_flags = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        rd_we;
    logic [3:0]  flags_out;
    logic        status_restore;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dp_alu_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .rn_is_pc(rn_is_pc), .instr_addr(instr_addr), .rn_value(rn_value),
        .shift_by_reg(shift_by_reg), .op2_value(op2_value),
        .shifter_carry(shifter_carry), .flags_in(flags_in), .set_flags(set_flags),
        .rd_is_pc(rd_is_pc), .saved_flags(saved_flags), .out_valid(out_valid),
        .result(result), .rd_we(rd_we), .flags_out(flags_out),
        .status_restore(status_restore)
    );

    // Reference: returns {valid, restore, we, N, Z, C, V, result}.
    function automatic logic [38:0] ref_model(
        input logic [3:0] op, input logic [31:0] rv, input logic [31:0] b,
        input logic pcr, input logic [31:0] ia, input logic sbr, input logic shc,
        input logic [3:0] fl, input logic sf, input logic rdpc, input logic [3:0] sv);
        logic [31:0] a;
        logic [31:0] r;
        longint unsigned ua, ub, uc;
        longint sa, sb, sr;
        logic c, v, cmp, arith, rest;
        logic [3:0] nf;
        a = pcr ? (ia + (sbr ? 32'd12 : 32'd8)) : rv;
        ua = {32'd0, a}; ub = {32'd0, b}; uc = {63'd0, fl[1]};
        sa = longint'($signed(a)); sb = longint'($signed(b));
        c = 1'b0; sr = 0;
        cmp = (op >= 4'h8 && op <= 4'hB);
        arith = (op >= 4'h2 && op <= 4'h7) || op == 4'hA || op == 4'hB;
        case (op)
            4'h0, 4'h8: r = a & b;
            4'h1, 4'h9: r = a ^ b;
            4'hC: r = a | b;
            4'hD: r = b;
            4'hE: r = a & ~b;
            4'hF: r = ~b;
            4'h2, 4'hA: begin r = a - b; c = (ua >= ub); sr = sa - sb; end
            4'h3: begin r = b - a; c = (ub >= ua); sr = sb - sa; end
            4'h4, 4'hB: begin r = a + b; c = (ua + ub) > 64'hFFFF_FFFF; sr = sa + sb; end
            4'h5: begin r = a + b + fl[1]; c = (ua + ub + uc) > 64'hFFFF_FFFF; sr = sa + sb + longint'(uc); end
            4'h6: begin r = a - b - (1 - fl[1]); c = (ua >= ub + 1 - uc); sr = sa - sb - 1 + longint'(uc); end
            default: begin r = b - a - (1 - fl[1]); c = (ub >= ua + 1 - uc); sr = sb - sa - 1 + longint'(uc); end
        endcase
        v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        rest = sf && rdpc && !cmp;
        if (!sf) nf = fl;
        else if (rest) nf = sv;
        else nf = {r[31], (r == 32'd0), arith ? c : shc, arith ? v : fl[0]};
        return {1'b1, rest, !cmp, nf, r};
    endfunction

    task automatic check(input string req, input logic [38:0] got, input logic [38:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input string req, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic pcr, input logic sbr,
                         input logic shc, input logic [3:0] fl, input logic sf,
                         input logic rdpc, input logic [3:0] sv);
        logic [38:0] exp;
        @(negedge clk);
        in_valid = 1'b1; op_code = op; rn_value = a; op2_value = b;
        rn_is_pc = pcr; instr_addr = 32'h0000_1F00 + {a[7:2], 2'b00}; shift_by_reg = sbr;
        shifter_carry = shc; flags_in = fl; set_flags = sf; rd_is_pc = rdpc; saved_flags = sv;
        exp = ref_model(op, a, b, pcr, instr_addr, sbr, shc, fl, sf, rdpc, sv);
        @(posedge clk);
        #2;
        check(req, {out_valid, status_restore, rd_we, flags_out, result}, exp);
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] pick_val(input int unsigned sel);
        case (sel % 8)
            0: return 32'h8000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7FFF_FFFF;
            3: return 32'h0000_0000;
            4: return 32'h0000_0001;
            default: return $urandom;
        endcase
    endfunction

    function automatic string req_for(input logic [3:0] op, input logic sf, input logic pcr);
        if (pcr) return "R6";
        if (op >= 4'h8 && op <= 4'hB) return "R2";
        if (!sf) return ((op >= 4'h2 && op <= 4'h7) ? "R3" : "R8");
        if ((op >= 4'h2 && op <= 4'h7)) return "R4";
        return "R5";
    endfunction

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        // R11: reset state
        check("R11", {out_valid, status_restore, rd_we, flags_out, result}, 39'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: each logical opcode, flags off (R12 order seen via held flags)
        apply("R1", 4'h0, 32'hF0F0_1234, 32'hFF00_FF00, 0, 0, 0, 4'b1010, 0, 0, 4'h0);
        apply("R1", 4'h1, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, 0, 4'b0101, 0, 0, 4'h0);
        apply("R1", 4'hC, 32'h0000_00F0, 32'h0F00_0000, 0, 0, 0, 4'h0, 0, 0, 4'h0);
        apply("R1", 4'hD, 32'h1234_5678, 32'hCAFE_0001, 0, 0, 0, 4'h0, 0, 0, 4'h0);
        apply("R1", 4'hE, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 0, 0, 4'h0, 0, 0, 4'h0);
        apply("R1", 4'hF, 32'h0, 32'h8000_0000, 0, 0, 0, 4'h0, 0, 0, 4'h0);
        // R3: carry-in convention on SBC/RSC with C=0 and C=1
        apply("R3", 4'h6, 32'd10, 32'd3, 0, 0, 0, 4'b0000, 0, 0, 4'h0);
        apply("R3", 4'h6, 32'd10, 32'd3, 0, 0, 0, 4'b0010, 0, 0, 4'h0);
        apply("R3", 4'h7, 32'd3, 32'd10, 0, 0, 0, 4'b0000, 0, 0, 4'h0);
        apply("R3", 4'h3, 32'd5, 32'd2, 0, 0, 0, 4'b0000, 0, 0, 4'h0);
        // R4: overflow and borrow corners
        apply("R4", 4'h4, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 4'h0, 1, 0, 4'h0);
        apply("R4", 4'h2, 32'h8000_0000, 32'd1, 0, 0, 0, 4'h0, 1, 0, 4'h0);
        apply("R4", 4'h2, 32'd0, 32'd1, 0, 0, 0, 4'h0, 1, 0, 4'h0);
        apply("R4", 4'h5, 32'hFFFF_FFFF, 32'd0, 0, 0, 0, 4'b0010, 1, 0, 4'h0);
        // R7: zero and negative from compare results
        apply("R7", 4'hA, 32'h8000_0000, 32'h8000_0000, 0, 0, 1, 4'h0, 1, 0, 4'h0);
        apply("R7", 4'h9, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 4'h0, 1, 0, 4'h0);
        // R5: logical flag setting keeps V, takes shifter carry
        apply("R5", 4'hD, 32'h0, 32'h0, 0, 0, 1, 4'b0001, 1, 0, 4'h0);
        // R6: program counter operand, both offsets, rn_value ignored
        apply("R6", 4'h4, 32'hDEAD_BEEF, 32'd0, 1, 0, 0, 4'h0, 0, 0, 4'h0);
        apply("R6", 4'h4, 32'hDEAD_BEEF, 32'd0, 1, 1, 0, 4'h0, 0, 0, 4'h0);
        // R9: restore from saved flags; compare with rd_is_pc does not restore
        apply("R9", 4'h4, 32'd1, 32'd2, 0, 0, 0, 4'b0000, 1, 1, 4'b1011);
        apply("R9", 4'hA, 32'd1, 32'd1, 0, 0, 0, 4'b0000, 1, 1, 4'b1011);
        // R10: idle cycle after an operation clears the valid-gated outputs
        @(negedge clk);
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || rd_we !== 1'b0 || status_restore !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: got %b%b%b expected 000", out_valid, rd_we, status_restore);
        end

        // Random operations across every opcode.
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            logic sf, pcr;
            op = 4'($urandom);
            sf = 1'($urandom);
            pcr = ($urandom % 8) == 0;
            apply(req_for(op, sf, pcr), op, pick_val($urandom), pick_val($urandom), pcr,
                  1'($urandom), 1'($urandom), 4'($urandom), sf,
                  ($urandom % 16) == 0, 4'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule